// File: doc/BRIEF.md
# Cascadable Prioritised Interrupt Controller

This block gathers 32 interrupt request lines into a pending register. Each line has its own active polarity and its own choice between level and edge triggering. A per-line enable turns the pending register into a masked view. Each line is also steered to one of two outputs: an urgent output or an ordinary output. Software reaches all of this through a single-cycle register port. Writes take effect on the clock edge, and reads return data combinationally in the same cycle. A read-only vector register names the most urgent pending line.

Lines are numbered 0 to 31, and line n lives in register bit 31−n. That puts line 0 in the most significant bit, and line 0 wins priority. The ordinary output is a level signal. It can drive one request line of a second, identical controller, so controllers can be chained into a tree. Every input passes through a two-stage synchronizer before any detection is done.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the pending, enable, urgent-select and mode registers read 0, the polarity register reads 0xFFFFFFFF, both outputs are low and the vector register reads 0.
- R2: Line n is pin irq_in[31−n] and bit 31−n of every register, so line 0 is the most significant bit.
- R3: Mode bit 0 selects level sensing. While the polarity-corrected line is active, its pending bit is set. It is still set after an acknowledge if the line stays active. Polarity bit 1 means active high, and 0 means active low.
- R4: Mode bit 1 selects edge sensing. Polarity bit 1 means a rising edge and 0 means a falling edge. Only a qualifying transition sets the pending bit. Holding the line at its active level does not set the bit again after an acknowledge.
- R5: Writing the pending register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFFFFFF clears every line.
- R6: The masked register (address 5) reads pending AND enable (address 1). A line latches as pending even while disabled, and enabling it later raises the output.
- R7: The urgent-select register (address 2) routes a line to urgent_irq when its bit is 1 and to normal_irq when it is 0. Each output is the OR of the masked bits in its group.
- R8: The vector register (address 6) returns the lowest-numbered line among all masked pending lines. The line number is in bits 4:0 and a valid flag is in bit 31. With nothing pending it reads 0.
- R9: A downstream controller's normal_irq, wired to one line of an upstream controller, keeps that upstream line pending until the downstream source is cleared. The upstream bit stays clear only when it is acknowledged after the downstream one.
- R10: An input change reaches the pending register on the third rising clock edge after it is applied. It is not yet visible after two edges.
- R11: Polarity is written at address 3 and mode at address 4. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Request lines, line n on bit 31−n |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| urgent_irq | output | 1 | OR of masked lines selected as urgent |
| normal_irq | output | 1 | OR of masked lines selected as ordinary, usable as a cascade source |

## Verification
The hardest situation to reach is the acknowledge race in a chain. The upstream bit is cleared while the downstream request is still asserted, so the clear and the level re-set fall on the same edge. The bench instantiates a second controller and wires its ordinary output into line 31 of the device under test. It latches an edge event downstream, then acknowledges upstream first and reads the bit back. Only after that does it clear the downstream source, wait out the synchronizer and acknowledge upstream again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PEND   = 3'd0,
    A_ENABLE = 3'd1,
    A_URGENT = 3'd2,
    A_POLAR  = 3'd3,
    A_MODE   = 3'd4,
    A_MASKED = 3'd5,
    A_VECTOR = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] act;
  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] hit;

  always_comb begin
    act    = line_i ^ ~pol_i;
    hit    = (mode_i & act & ~prev_q) | (~mode_i & act);
    prev_d = act;
    pend_d = (pend_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R3: an active level-mode line is pending on the following cycle
  a_r3_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(~mode_i & act)) == $past(~mode_i & act)));

  // R4: an edge-mode bit rises only on a qualifying transition
  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & $past(mode_i) & ~$past(act & ~prev_q)) == '0));

  // R5: a cleared bit with no fresh event reads zero
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_i & ~act)) == '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        idx_o   = IW'(N - 1 - i);
        valid_o = 1'b1;
      end
    end
  end

  // R8: reported line is pending and no lower-numbered line is
  a_r8_winner: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (vec_i[N-1-int'(idx_o)] && ((vec_i >> (N-1-int'(idx_o))) == 1)));

  a_r8_none: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (vec_i == '0));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  output logic              urgent_irq,
  output logic              normal_irq
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0] en_q, en_d, urg_q, urg_d, pol_q, pol_d, mode_q, mode_d;
  logic [N-1:0] line_s, pend, clr, masked;
  logic [IW-1:0] win_idx;
  logic          win_valid;
  logic          wr;

  assign wr = bus_sel & bus_we;

  irq_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_in), .q_o(line_s)
  );

  irq_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .pol_i(pol_q),
    .mode_i(mode_q), .clr_i(clr), .pend_o(pend)
  );

  assign masked = pend & en_q;

  irq_prio #(.N(N), .IW(IW)) u_prio (
    .clk(clk), .rst_n(rst_n), .vec_i(masked), .idx_o(win_idx), .valid_o(win_valid)
  );

  always_comb begin
    en_d   = en_q;
    urg_d  = urg_q;
    pol_d  = pol_q;
    mode_d = mode_q;
    clr    = '0;
    if (wr) begin
      unique case (bus_addr)
        A_PEND:   clr    = bus_wdata;
        A_ENABLE: en_d   = bus_wdata;
        A_URGENT: urg_d  = bus_wdata;
        A_POLAR:  pol_d  = bus_wdata;
        A_MODE:   mode_d = bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      urg_q  <= '0;
      pol_q  <= '1;
      mode_q <= '0;
    end else if (wr) begin
      en_q   <= en_d;
      urg_q  <= urg_d;
      pol_q  <= pol_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_PEND:   bus_rdata = pend;
      A_ENABLE: bus_rdata = en_q;
      A_URGENT: bus_rdata = urg_q;
      A_POLAR:  bus_rdata = pol_q;
      A_MODE:   bus_rdata = mode_q;
      A_MASKED: bus_rdata = masked;
      A_VECTOR: begin
        bus_rdata[IW-1:0] = win_idx;
        bus_rdata[N-1]    = win_valid;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign urgent_irq = |(masked & urg_q);
  assign normal_irq = |(masked & ~urg_q);

  // R7: each output implies a pending enabled line of its own group
  a_r7_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_irq |-> ((pend & en_q & urg_q) != '0));

  a_r7_normal: assert property (@(posedge clk) disable iff (!rst_n)
    normal_irq |-> ((pend & en_q & ~urg_q) != '0));

  // R6: a disabled line never drives an output
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!urgent_irq && !normal_irq));
endmodule

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ext = '0;
  logic [31:0] ext_c = '0;
  logic        sel0 = 1'b0, sel1 = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        urg0, nrm0, urg1, nrm1;
  logic [31:0] pin0;
  int          runs = 0, fails = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  assign pin0 = {ext[31:1], nrm1};

  cascade_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(pin0), .bus_sel(sel0), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0),
    .urgent_irq(urg0), .normal_irq(nrm0)
  );

  cascade_irq_ctrl u_child (
    .clk(clk), .rst_n(rst_n), .irq_in(ext_c), .bus_sel(sel1), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
    .urgent_irq(urg1), .normal_irq(nrm1)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit child, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel0 = !child; sel1 = child; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit child, input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = child ? rdata1 : rdata0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cleanup();
    ext = '0; ext_c = '0;
    wr(0, 3'd3, '1); wr(0, 3'd4, '0); wr(0, 3'd1, '0); wr(0, 3'd2, '0);
    wr(1, 3'd3, '1); wr(1, 3'd4, '0); wr(1, 3'd1, '0); wr(1, 3'd2, '0);
    settle();
    wr(1, 3'd0, '1); wr(0, 3'd0, '1);
    settle();
    wr(0, 3'd0, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 3'd0, v); chk("R1 pending", v, 32'h0);
    rd(0, 3'd1, v); chk("R1 enable", v, 32'h0);
    rd(0, 3'd2, v); chk("R1 urgent", v, 32'h0);
    rd(0, 3'd3, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    rd(0, 3'd4, v); chk("R1 mode", v, 32'h0);
    rd(0, 3'd6, v); chk("R1 vector", v, 32'h0);
    chk("R1 outputs", {30'd0, urg0, nrm0}, 32'h0);
    rd(0, 3'd7, v); chk("R11 unused addr", v, 32'h0);
  endtask

  task automatic t_sync_level();
    logic [31:0] v;
    @(negedge clk); ext[26] = 1'b1;             // line 5
    @(negedge clk); rd(0, 3'd0, v); chk("R10 after 1 edge", v, 32'h0);
    @(negedge clk); rd(0, 3'd0, v); chk("R10 after 2 edges", v, 32'h0);
    @(negedge clk); rd(0, 3'd0, v); chk("R10 after 3 edges", v, 32'h0400_0000);
    wr(0, 3'd0, 32'h0400_0000);
    rd(0, 3'd0, v); chk("R3 level re-set after ack", v, 32'h0400_0000);
    ext[26] = 1'b0; settle();
    wr(0, 3'd0, 32'h0400_0000);
    rd(0, 3'd0, v); chk("R3 level clears when idle", v, 32'h0);
    wr(0, 3'd3, 32'hFEFF_FFFF);                  // line 7 active low
    settle();
    rd(0, 3'd0, v); chk("R3 active-low sets", v, 32'h0100_0000);
    rd(0, 3'd3, v); chk("R11 polarity readback", v, 32'hFEFF_FFFF);
    ext[24] = 1'b1; settle();
    wr(0, 3'd0, 32'h0100_0000);
    rd(0, 3'd0, v); chk("R3 active-low idle high", v, 32'h0);
    cleanup();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(0, 3'd4, 32'h0010_0000);                  // line 11 edge
    rd(0, 3'd4, v); chk("R11 mode readback", v, 32'h0010_0000);
    ext[20] = 1'b1; settle();
    rd(0, 3'd0, v); chk("R4 rising sets", v, 32'h0010_0000);
    wr(0, 3'd0, 32'h0010_0000); settle();
    rd(0, 3'd0, v); chk("R4 held high no re-set", v, 32'h0);
    ext[20] = 1'b0; settle();
    rd(0, 3'd0, v); chk("R4 falling ignored", v, 32'h0);
    wr(0, 3'd3, 32'hFFEF_FFFF); settle();
    wr(0, 3'd0, '1);
    ext[20] = 1'b1; settle();
    rd(0, 3'd0, v); chk("R4 rising ignored in falling mode", v, 32'h0);
    ext[20] = 1'b0; settle();
    rd(0, 3'd0, v); chk("R4 falling sets", v, 32'h0010_0000);
    cleanup();
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(0, 3'd4, 32'hFFFF_FFFE);
    ext = 32'h0F0F_0000; settle(); ext = '0; settle();
    rd(0, 3'd0, v); chk("R5 latched set", v, 32'h0F0F_0000);
    wr(0, 3'd0, 32'h0);
    rd(0, 3'd0, v); chk("R5 zero write no effect", v, 32'h0F0F_0000);
    wr(0, 3'd0, 32'h0100_0000);
    rd(0, 3'd0, v); chk("R5 single clear", v, 32'h0E0F_0000);
    wr(0, 3'd0, 32'hFFFF_FFFF);
    rd(0, 3'd0, v); chk("R5 clear all", v, 32'h0);
    cleanup();
  endtask

  task automatic t_prio_mask();
    logic [31:0] v;
    wr(0, 3'd4, 32'hFFFF_FFFE);
    ext = 32'h0000_0108; settle(); ext = '0; settle();
    rd(0, 3'd5, v); chk("R6 masked while disabled", v, 32'h0);
    chk("R6 output quiet while disabled", {31'd0, nrm0}, 32'h0);
    wr(0, 3'd1, 32'h0000_0008);
    rd(0, 3'd5, v); chk("R6 masked after enable", v, 32'h0000_0008);
    chk("R6 output after enable", {31'd0, nrm0}, 32'h1);
    rd(0, 3'd6, v); chk("R2 bit3 is line 28", v, 32'h8000_001C);
    wr(0, 3'd1, '1);
    rd(0, 3'd6, v); chk("R8 lower line wins", v, 32'h8000_0017);
    wr(0, 3'd2, 32'h0000_0108);
    chk("R7 urgent group", {30'd0, urg0, nrm0}, 32'h2);
    wr(0, 3'd2, 32'h0000_0100);
    chk("R7 split groups", {30'd0, urg0, nrm0}, 32'h3);
    wr(0, 3'd0, '1);
    rd(0, 3'd6, v); chk("R8 none pending", v, 32'h0);
    cleanup();
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    wr(1, 3'd4, 32'h8000_0000);
    wr(1, 3'd1, 32'h8000_0000);
    wr(0, 3'd1, 32'h0000_0001);
    ext_c[31] = 1'b1; settle(); ext_c[31] = 1'b0; settle();
    rd(0, 3'd6, v); chk("R9 upstream sees line 31", v, 32'h8000_001F);
    wr(0, 3'd0, 32'h1);
    rd(0, 3'd0, v); chk("R9 early ack re-sets", v, 32'h1);
    wr(1, 3'd0, 32'h8000_0000); settle();
    wr(0, 3'd0, 32'h1);
    rd(0, 3'd0, v); chk("R9 ordered ack clears", v, 32'h0);
    chk("R9 upstream output low", {31'd0, nrm0}, 32'h0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_level();
    t_edge();
    t_w1c();
    t_prio_mask();
    t_cascade();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule